// File: doc/BRIEF.md
# Serial One-Hot Stream Checker

This block tells whether a serial bit stream is a one-hot code: over the whole stream, exactly one bit may be 1. Bits arrive one per clock on a single data line. A qualifier decides which clocks carry a bit. The stream has no fixed length. Because of that, the block never stores the bits. A three-state saturating tracker records whether no 1, exactly one 1, or more than one 1 has been seen since the last clear.

A synchronous clear input starts a new stream. The verdict output is registered and describes every qualified bit accepted up to the last clock edge. The same top also has a combinational check of a parallel word. Its width is a parameter with a default of 16 bits.

Top module: `onehot_checker`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `stream_ok` is 0. Reset puts the tracker in the no-ones state.
- R2: A qualified bit is a clock edge where `bit_en`=1 and `clr`=0. A qualified `bit_in`=1 accepted in the no-ones state drives `stream_ok` to 1 after that edge.
- R3: A second qualified 1 drives `stream_ok` to 0. It stays 0 for any later bits until the next clear.
- R4: A qualified `bit_in`=0 leaves `stream_ok` unchanged, however long the stream runs.
- R5: On an edge where `bit_en`=0, `bit_in` has no effect and `stream_ok` keeps its value.
- R6: An edge with `clr`=1 returns the tracker to the no-ones state, so `stream_ok` reads 0. An empty stream reports 0.
- R7: When `clr`=1 and `bit_en`=1 with `bit_in`=1 occur on the same edge, the clear wins and `stream_ok` is 0 after that edge.
- R8: `word_ok` is 1 exactly when `word_in` has a single bit set. It is 0 for the all-zero word. It is combinational and needs no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous start of a new stream |
| bit_en | input | 1 | Qualifier: when high, `bit_in` carries a bit on this edge |
| bit_in | input | 1 | Serial data bit |
| stream_ok | output | 1 | High when exactly one qualified 1 has been seen since clear |
| word_in | input | WORD_W | Parallel word to check |
| word_ok | output | 1 | High when `word_in` is one-hot |

## Verification
`stream_ok` comes from one state register. Its value for a bit presented before edge k is due just after edge k. The bench drives inputs on the falling edge and compares `stream_ok` 1 ns after the next rising edge against a reference tracker in the bench that was updated at that same edge. `word_ok` has no latency. After each new `word_in`, the bench waits 1 ns of settling time and compares `word_ok` with a bit count computed in the bench. Random qualified and unqualified traffic, long zero runs, clears that collide with a 1, and single-bit, zero and dense words are all checked in this way.

// File: rtl/onehot_pkg.sv
package onehot_pkg;

    typedef enum logic [1:0] {
        TRK_NONE = 2'd0,
        TRK_ONE  = 2'd1,
        TRK_MANY = 2'd2
    } trk_state_e;

    typedef struct packed {
        trk_state_e state;
    } trk_regs_t;

    localparam trk_regs_t TRK_RESET = '{state: TRK_NONE};

endpackage

// File: rtl/onehot_stream_tracker.sv
module onehot_stream_tracker
    import onehot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_en,
    input  logic bit_in,
    output logic seen_one
);

    trk_regs_t r_d;
    trk_regs_t r_q;
    logic      hit;

    assign hit = bit_en & bit_in;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.state = TRK_NONE;
        end else if (hit) begin
            case (r_q.state)
                TRK_NONE: r_d.state = TRK_ONE;
                TRK_ONE:  r_d.state = TRK_MANY;
                default:  r_d.state = TRK_MANY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= TRK_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign seen_one = (r_q.state == TRK_ONE);

endmodule

// File: rtl/onehot_word_check.sv
module onehot_word_check #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_onehot
);

    logic [WORD_W-1:0] low_cleared;
    logic              nonzero;

    always_comb begin
        low_cleared = word & (word - WORD_W'(1));
        nonzero     = |word;
        is_onehot   = nonzero && (low_cleared == '0);
    end

endmodule

// File: rtl/onehot_checker.sv
module onehot_checker #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              stream_ok,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_ok
);

    onehot_stream_tracker u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .seen_one (stream_ok)
    );

    onehot_word_check #(.WORD_W(WORD_W)) u_word (
        .word      (word_in),
        .is_onehot (word_ok)
    );

endmodule

// File: rtl/onehot_checker_sva.sv
module onehot_checker_sva #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              bit_en,
    input logic              bit_in,
    input logic              stream_ok,
    input logic [WORD_W-1:0] word_in,
    input logic              word_ok
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (!stream_ok); // R1
        end
    end

    AST_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bit_en && bit_in && stream_ok) |=> !stream_ok); // R3

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bit_en && !bit_in) |=> $stable(stream_ok)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !bit_en) |=> $stable(stream_ok)); // R5

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !stream_ok); // R6

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && bit_en && bit_in) |=> !stream_ok); // R7

    AST_WORD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        word_ok == ($countones(word_in) == 1)); // R8

endmodule

bind onehot_checker onehot_checker_sva #(.WORD_W(WORD_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .stream_ok (stream_ok),
    .word_in   (word_in),
    .word_ok   (word_ok)
);

// File: tb/sim_onehot_checker.sv
`timescale 1ns/1ps
module sim_onehot_checker;

    localparam int WORD_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              bit_en = 1'b0;
    logic              bit_in = 1'b0;
    logic              stream_ok;
    logic [WORD_W-1:0] word_in = '0;
    logic              word_ok;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;   // saturating count of qualified ones: 0, 1, 2

    always #2 clk = ~clk;

    onehot_checker #(.WORD_W(WORD_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .stream_ok (stream_ok),
        .word_in   (word_in),
        .word_ok   (word_ok)
    );

    function automatic logic exp_word(input logic [WORD_W-1:0] w);
        int n = 0;
        for (int i = 0; i < WORD_W; i++) n += int'(w[i]);
        return n == 1;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic e, input logic b, input string req);
        @(negedge clk);
        clr = c; bit_en = e; bit_in = b;
        @(posedge clk);
        if (c) ref_cnt = 0;
        else if (e && b && ref_cnt < 2) ref_cnt++;
        #1;
        check(req, stream_ok, ref_cnt == 1);
    endtask

    task automatic word(input logic [WORD_W-1:0] w);
        word_in = w;
        #1;
        check("R8", word_ok, exp_word(w));
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0123));
        // R1: reset state
        #5;
        check("R1", stream_ok, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", stream_ok, 1'b0);

        // R6: empty stream is invalid
        step(1, 0, 0, "R6");
        // R2: first one
        step(0, 1, 1, "R2");
        // R4: long zero run keeps verdict
        for (int i = 0; i < 300; i++) step(0, 1, 0, "R4");
        // R5: unqualified ones ignored
        for (int i = 0; i < 20; i++) step(0, 0, 1, "R5");
        // R3: second one, then sticky
        step(0, 1, 1, "R3");
        step(0, 1, 0, "R3");
        step(0, 1, 1, "R3");
        // R6: clear then single one
        step(1, 0, 0, "R6");
        step(0, 1, 1, "R6");
        // R7: clear collides with a one
        step(1, 1, 1, "R7");
        step(0, 0, 1, "R5");
        step(0, 1, 1, "R2");
        step(1, 1, 1, "R7");

        // random serial traffic
        for (int i = 0; i < 3000; i++) begin
            logic c, e, b;
            c = ($urandom_range(0, 39) == 0);
            e = ($urandom_range(0, 2) != 0);
            b = ($urandom_range(0, 7) == 0);
            step(c, e, b, "R4");
        end

        // R8: directed words
        word('0);
        word('1);
        for (int k = 0; k < WORD_W; k++) word(WORD_W'(1) << k);
        word(16'h8001);
        word(16'h0003);
        // R8: random words
        for (int i = 0; i < 500; i++) begin
            if (i % 2 == 0) word(WORD_W'(1) << $urandom_range(0, WORD_W - 1));
            else word(WORD_W'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule